// File: doc/BRIEF.md
# 4x4 Inverse Transform Reconstructor

This block rebuilds a 4x4 tile of 8-bit pixels from sixteen signed residual coefficients and a 4x4 prediction tile. The transform is an integer shift-and-add butterfly. Its odd inputs enter at half weight through an arithmetic right shift. The block runs the butterfly across every row, stores the results transposed, and then runs the same butterfly across every column. Each final value is scaled down by 64 with round-to-nearest and added to the prediction pixel at the same position. The sum is clamped to the 8-bit pixel range.

The block has two load ports, one for coefficients and one for prediction pixels, and each takes one word per cycle. A start pulse launches the computation. The row pass takes one cycle and the column pass plus reconstruction takes a second. A one-cycle done pulse then marks the refreshed pixel output. When the coefficients have been used, the block clears its coefficient store. The next tile can therefore load only its non-zero coefficients.

Top module: `idct4_recon`

## Requirements
- R1: After reset, busy and done are low and all sixteen output pixels read zero.
- R2: A start seen while idle raises busy in the next cycle. Busy stays high for exactly two cycles. Done is high for exactly one cycle, the cycle in which busy has returned low.
- R3: Each 4-element vector s0..s3 is transformed as follows. First z0=s0+s2, z1=s0-s2, z2=(s1>>>1)-s3 and z3=s1+(s3>>>1). The outputs are then z0+z3, z1+z2, z1-z2 and z0-z3. This is applied to the four rows first and then to the four columns of the row results, with no overflow for any 16-bit inputs.
- R4: Each column-pass value v becomes (v+32)>>>6 (arithmetic shift) before it is added to the prediction.
- R5: Each output pixel is the sum of that scaled residual and the prediction pixel, clamped to 0..255.
- R6: Completing a tile sets every stored coefficient to zero. A second start with no new loads therefore reproduces the prediction exactly.
- R7: A start raised while busy has no effect. Done still pulses once, and busy falls after its two cycles.
- R8: Coefficient and prediction writes are accepted only while not busy. A write made while busy changes neither the current result nor the stored state.
- R9: The pixel output changes only on the edge that raises done. It holds between tiles, including while new loads arrive.
- R10: Index i on the load ports and lane i of the pixel output (bits 8i+7..8i) both address row i/4, column i%4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 4 | Coefficient position, row*4+column |
| coef_data | input | 16 | Signed coefficient value |
| pred_we | input | 1 | Prediction write strobe |
| pred_idx | input | 4 | Prediction position, row*4+column |
| pred_data | input | 8 | Unsigned prediction pixel |
| start | input | 1 | Launch the transform on the stored tile |
| busy | output | 1 | High during the row and column passes |
| done | output | 1 | One-cycle pulse when the output tile is refreshed |
| pix_out | output | 128 | Sixteen reconstructed pixels, lane i at bits 8i+7..8i |

## Verification
A wrong butterfly term or a wrong transpose shows up in the first tile that is launched after the fault, and the output lanes carrying it differ exactly two cycles after start. Every single coefficient position is swept with several magnitudes, so a lane swap shows as a transposed or misplaced impulse response. A coefficient store that fails to clear, or that takes a write while busy, is invisible in its own tile. It appears in the following tile, which the bench launches with no new loads and compares against the plain prediction. Errors in the rounding offset or the clamp appear only at the ±32 thresholds and at saturating DC values, and those cases are driven explicitly.

// File: rtl/idct4_pkg.sv
package idct4_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ROW,
        PH_COL
    } phase_e;

    function automatic int lane(input int r, input int c, input int n);
        return r * n + c;
    endfunction

endpackage

// File: rtl/idct4_butterfly.sv
module idct4_butterfly #(
    parameter int W = 20
) (
    input  logic signed [W-1:0] s [4],
    output logic signed [W-1:0] o [4]
);
    logic signed [W-1:0] even_sum, even_dif, odd_lo, odd_hi;

    always_comb begin
        even_sum = s[0] + s[2];
        even_dif = s[0] - s[2];
        odd_lo   = (s[1] >>> 1) - s[3];
        odd_hi   = s[1] + (s[3] >>> 1);
        o[0] = even_sum + odd_hi;
        o[1] = even_dif + odd_lo;
        o[2] = even_dif - odd_lo;
        o[3] = even_sum - odd_hi;
    end
endmodule

// File: rtl/idct4_pixel_add.sv
module idct4_pixel_add #(
    parameter int W     = 20,
    parameter int PIX_W = 8,
    parameter int SH    = 6
) (
    input  logic signed [W-1:0]     resid,
    input  logic        [PIX_W-1:0] pred,
    output logic        [PIX_W-1:0] pix
);
    localparam logic signed [W-1:0] HALF = W'(1 << (SH - 1));
    localparam logic signed [W-1:0] PMAX = W'((1 << PIX_W) - 1);

    logic signed [W-1:0] biased, scaled, total;

    always_comb begin
        biased = resid + HALF;
        scaled = biased >>> SH;
        total  = scaled + $signed({{(W - PIX_W){1'b0}}, pred});
        if (total < 0)
            pix = '0;
        else if (total > PMAX)
            pix = PMAX[PIX_W-1:0];
        else
            pix = total[PIX_W-1:0];
    end
endmodule

// File: rtl/idct4_recon.sv
module idct4_recon
    import idct4_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int PIX_W  = 8,
    parameter int INT_W  = 20,
    parameter int RND_SH = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 coef_we,
    input  logic [3:0]           coef_idx,
    input  logic [COEF_W-1:0]    coef_data,
    input  logic                 pred_we,
    input  logic [3:0]           pred_idx,
    input  logic [PIX_W-1:0]     pred_data,
    input  logic                 start,
    output logic                 busy,
    output logic                 done,
    output logic [16*PIX_W-1:0]  pix_out
);
    localparam int N  = 4;
    localparam int NE = N * N;

    phase_e                    phase_q;
    logic                      done_q;
    logic signed [COEF_W-1:0]  coef_q [NE];
    logic        [PIX_W-1:0]   pred_q [NE];
    logic signed [INT_W-1:0]   mid_q  [NE];
    logic        [PIX_W-1:0]   pix_q  [NE];

    logic signed [INT_W-1:0]   row_in  [N][N];
    logic signed [INT_W-1:0]   row_out [N][N];
    logic signed [INT_W-1:0]   col_in  [N][N];
    logic signed [INT_W-1:0]   col_out [N][N];
    logic        [PIX_W-1:0]   pix_new [NE];

    // Row pass: vector r holds row r of the coefficient tile.
    // Column pass: vector c holds column c of the row results (stored transposed).
    for (genvar r = 0; r < N; r++) begin : g_vec
        for (genvar k = 0; k < N; k++) begin : g_elem
            assign row_in[r][k] = INT_W'(coef_q[lane(r, k, N)]);
            assign col_in[r][k] = mid_q[lane(r, k, N)];
        end
        idct4_butterfly #(.W(INT_W)) u_row (.s(row_in[r]), .o(row_out[r]));
        idct4_butterfly #(.W(INT_W)) u_col (.s(col_in[r]), .o(col_out[r]));
    end

    // col_out[c][rr] is the final value at row rr, column c.
    for (genvar rr = 0; rr < N; rr++) begin : g_prow
        for (genvar cc = 0; cc < N; cc++) begin : g_pcol
            idct4_pixel_add #(.W(INT_W), .PIX_W(PIX_W), .SH(RND_SH)) u_add (
                .resid (col_out[cc][rr]),
                .pred  (pred_q[lane(rr, cc, N)]),
                .pix   (pix_new[lane(rr, cc, N)])
            );
            assign pix_out[lane(rr, cc, N)*PIX_W +: PIX_W] = pix_q[lane(rr, cc, N)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b0;
            for (int i = 0; i < NE; i++) begin
                coef_q[i] <= '0;
                pred_q[i] <= '0;
                mid_q[i]  <= '0;
                pix_q[i]  <= '0;
            end
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (coef_we) coef_q[coef_idx] <= coef_data;
                    if (pred_we) pred_q[pred_idx] <= pred_data;
                    if (start)   phase_q <= PH_ROW;
                end
                PH_ROW: begin
                    for (int r = 0; r < N; r++)
                        for (int c = 0; c < N; c++)
                            mid_q[c*N + r] <= row_out[r][c];
                    phase_q <= PH_COL;
                end
                PH_COL: begin
                    for (int i = 0; i < NE; i++) begin
                        pix_q[i]  <= pix_new[i];
                        coef_q[i] <= '0;
                    end
                    done_q  <= 1'b1;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase_q != PH_IDLE);
    assign done = done_q;
endmodule

// File: rtl/idct4_recon_chk.sv
module idct4_recon_chk #(
    parameter int OUT_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [OUT_W-1:0] pix_out
);
    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_busy_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_busy_two_cycles_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy ##1 !busy);

    p_start_launch_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |=> !busy);

    p_pix_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(pix_out));
endmodule

bind idct4_recon idct4_recon_chk #(.OUT_W(16*PIX_W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .pix_out (pix_out)
);

// File: tb/test_idct4_recon.sv
`timescale 1ns/1ps
module test_idct4_recon;
    logic         clk = 1'b0;
    logic         rst;
    logic         coef_we, pred_we, start;
    logic [3:0]   coef_idx, pred_idx;
    logic [15:0]  coef_data;
    logic [7:0]   pred_data;
    logic         busy, done;
    logic [127:0] pix_out;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int cf [16];
    int pr [16];
    int ex [16];

    always #2 clk = ~clk;

    idct4_recon i_idct4_recon (
        .clk(clk), .rst(rst),
        .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
        .pred_we(pred_we), .pred_idx(pred_idx), .pred_data(pred_data),
        .start(start), .busy(busy), .done(done), .pix_out(pix_out)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bfly(input int s0, input int s1, input int s2, input int s3,
                        output int o0, output int o1, output int o2, output int o3);
        int z0, z1, z2, z3;
        z0 = s0 + s2;
        z1 = s0 - s2;
        z2 = (s1 >>> 1) - s3;
        z3 = s1 + (s3 >>> 1);
        o0 = z0 + z3; o1 = z1 + z2; o2 = z1 - z2; o3 = z0 - z3;
    endtask

    task automatic model();
        int t [16];
        int f [16];
        int v;
        for (int r = 0; r < 4; r++)
            bfly(cf[4*r], cf[4*r+1], cf[4*r+2], cf[4*r+3],
                 t[4*r], t[4*r+1], t[4*r+2], t[4*r+3]);
        for (int c = 0; c < 4; c++)
            bfly(t[c], t[4+c], t[8+c], t[12+c], f[c], f[4+c], f[8+c], f[12+c]);
        for (int i = 0; i < 16; i++) begin
            v = ((f[i] + 32) >>> 6) + pr[i];
            ex[i] = (v < 0) ? 0 : ((v > 255) ? 255 : v);
        end
    endtask

    task automatic load_tile();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            coef_we = 1'b1; coef_idx = 4'(i); coef_data = 16'(cf[i]);
            pred_we = 1'b1; pred_idx = 4'(i); pred_data = 8'(pr[i]);
        end
        @(negedge clk);
        coef_we = 1'b0; pred_we = 1'b0;
    endtask

    task automatic run_tile(input bit poke, input bit busy_wr);
        int lat;
        @(negedge clk) start = 1'b1;
        @(negedge clk);
        start = poke;
        lat = 1;
        check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
        if (busy_wr) begin
            coef_we = 1'b1; coef_idx = 4'd0; coef_data = 16'd5000;
            pred_we = 1'b1; pred_idx = 4'd0; pred_data = 8'd7;
        end
        while (done !== 1'b1 && lat < 10) begin
            @(negedge clk);
            start = 1'b0; coef_we = 1'b0; pred_we = 1'b0;
            lat++;
        end
        check(lat == 3, "R2 done latency", lat, 3);
        check(busy === 1'b0, "R2 busy low at done", int'(busy), 0);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R7 single done, idle after", int'(done) + int'(busy), 0);
    endtask

    task automatic check_pix(input string req);
        for (int i = 0; i < 16; i++)
            check(int'(pix_out[8*i +: 8]) == ex[i], req, int'(pix_out[8*i +: 8]), ex[i]);
    endtask

    task automatic dc_case(input int dc, input int p, input string req);
        for (int i = 0; i < 16; i++) begin cf[i] = 0; pr[i] = p; end
        cf[0] = dc;
        model();
        load_tile();
        run_tile(1'b0, 1'b0);
        check_pix(req);
    endtask

    initial begin
        int vals [10] = '{1, -1, 31, -33, 64, -64, 1000, -1000, 32767, -32768};
        logic [127:0] held;
        rst = 1'b1; start = 1'b0; coef_we = 1'b0; pred_we = 1'b0;
        coef_idx = '0; pred_idx = '0; coef_data = '0; pred_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0 && done === 1'b0, "R1 flags after reset", int'(busy) + int'(done), 0);
        check(pix_out === '0, "R1 pixels after reset", int'(pix_out[31:0]), 0);

        // R3 zero residual reproduces a ramp prediction
        for (int i = 0; i < 16; i++) begin cf[i] = 0; pr[i] = 16 * i + 3; end
        model(); load_tile(); run_tile(1'b0, 1'b0); check_pix("R3 zero residual");

        // R4 rounding thresholds, R5 clamping
        dc_case(31, 100, "R4 dc 31 rounds down");
        dc_case(32, 100, "R4 dc 32 rounds up");
        dc_case(-32, 100, "R4 dc -32 rounds to zero");
        dc_case(-33, 100, "R4 dc -33 rounds to -1");
        dc_case(32767, 200, "R5 clamp high");
        dc_case(-32768, 50, "R5 clamp low");

        // R3/R10 impulse sweep over every position
        for (int pos = 0; pos < 16; pos++) begin
            for (int k = 0; k < 10; k++) begin
                for (int i = 0; i < 16; i++) begin cf[i] = 0; pr[i] = 128; end
                cf[pos] = vals[k];
                model(); load_tile(); run_tile(1'b0, 1'b0);
                check_pix("R10 impulse position");
            end
        end

        // R3 random full-range tiles
        for (int n = 0; n < 200; n++) begin
            for (int i = 0; i < 16; i++) begin
                cf[i] = (n < 100) ? int'($urandom_range(65535)) - 32768
                                  : int'($urandom_range(1023)) - 512;
                pr[i] = int'($urandom_range(255));
            end
            model(); load_tile(); run_tile(1'b0, 1'b0);
            check_pix("R3 random tile");
            // R6 store cleared: rerun with no loads
            if (n % 20 == 0) begin
                for (int i = 0; i < 16; i++) cf[i] = 0;
                model(); run_tile(1'b0, 1'b0);
                check_pix("R6 cleared store gives prediction");
            end
        end

        // R7 start pulsed while busy
        for (int i = 0; i < 16; i++) begin cf[i] = 40 * i - 300; pr[i] = 90; end
        model(); load_tile(); run_tile(1'b1, 1'b0);
        check_pix("R7 restart ignored");

        // R8 writes during busy ignored
        for (int i = 0; i < 16; i++) begin cf[i] = 7 * i - 50; pr[i] = 60 + i; end
        model(); load_tile(); run_tile(1'b0, 1'b1);
        check_pix("R8 busy write ignored this tile");
        for (int i = 0; i < 16; i++) cf[i] = 0;
        model(); run_tile(1'b0, 1'b0);
        check_pix("R8 busy write left no state");

        // R9 output holds across idle loads
        held = pix_out;
        for (int i = 0; i < 16; i++) begin cf[i] = 999; pr[i] = 1; end
        load_tile();
        repeat (4) @(negedge clk);
        check(pix_out === held, "R9 pixels held", int'(pix_out[31:0]), int'(held[31:0]));

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule